// File: doc/BRIEF.md
# Packed-Pair Radix-2 NTT Engine

This block runs a complete in-place radix-2 number theoretic transform of N residues modulo a runtime prime `q`. It works against a local cache whose 2·DW-bit words each carry two coefficients, the two operands of one butterfly. Every butterfly costs one cache read and one cache write. A precomputed twiddle table is read through a separate read-only port, one entry per butterfly. A pipelined datapath multiplies, reduces, adds and subtracts. The cache and the twiddle store sit outside the block, and both return read data one cycle after the address.

The caller places the coefficients, already in bit-reversed order, in the lower half of the cache (words 0 to N/2-1), sets `modulus` and pulses `start`. The engine walks log2(N) stages. In each general stage it reads two words that share a stage address, computes two butterflies, and writes the regrouped pairs back to the same two words. Each word then holds the operands of the next stage. The final stage reads adjacent words and writes the natural-order result into the upper half of the cache. A parameter selects the epoch, which offsets the twiddle address by N/2.

A small state machine runs the sequence. **ST_IDLE** moves to **ST_ISSUE** on `start`. **ST_ISSUE** issues N/2 reads, one per cycle, and then moves to **ST_DRAIN**. **ST_DRAIN** waits for the pipeline and the pending write to empty. It then returns to ST_ISSUE for the next stage, or, after the final stage, raises `done` and returns to ST_IDLE.

Top module: `ntt_packed_engine`

## Requirements
- R1: After reset the engine is idle: `busy` and `done` are low, and no cache read, cache write or twiddle read is issued.
- R2: A `start` pulse seen while idle raises `busy` in the next cycle. `done` is a single-cycle pulse exactly log2(N)·(N/2+6) cycles after the cycle in which `start` was sampled, which is one cycle after the last cache write, and `busy` falls together with it.
- R3: `start` has no effect while `busy` is high: the transform keeps its timing, produces one `done` pulse and gives the same results.
- R4: Input layout: cache word p (0 ≤ p < N/2) holds element 2p in bits [DW-1:0] and element 2p+1 in bits [2DW-1:DW]. Element e holds input coefficient a[bitrev(e)], where bitrev reverses the log2(N) index bits.
- R5: Output layout: word N/2+p holds X[2p] in bits [DW-1:0] and X[2p+1] in bits [2DW-1:DW], where X[k] = Σ a[j]·w^(j·k) mod q and w is the N-th root of unity that the twiddle table is built from.
- R6: Every result coefficient written to the cache lies in [0, q).
- R7: One transform issues exactly log2(N)·N/2 cache reads and the same number of cache writes, which is one of each per butterfly. All reads address the lower half of the cache.
- R8: One twiddle is read per butterfly, at consecutive addresses. Entry base + s·N/2 + c holds w^E. For stages s below the last, E = ((c>>1) mod 2^s)·N/2^(s+1). In the last stage, E = c.
- R9: The twiddle base is 0 when EPOCH is 0 and N/2 when EPOCH is 1, so the first twiddle address of a transform equals the base.
- R10: Each butterfly computes t = hi·w mod q from the upper coefficient hi and the lower coefficient u of the word it reads, and produces u+t mod q and u−t mod q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe, accepted only when idle |
| modulus | input | DW | Prime q, held stable during a transform |
| busy | output | 1 | High from launch until `done` |
| done | output | 1 | Single-cycle completion pulse |
| cache_rd_en | output | 1 | Cache read request |
| cache_rd_addr | output | log2(N) | Cache read word address |
| cache_rd_data | input | 2·DW | Cache read word, valid one cycle after the request |
| cache_wr_en | output | 1 | Cache write strobe |
| cache_wr_addr | output | log2(N) | Cache write word address |
| cache_wr_data | output | 2·DW | Cache write word |
| tw_rd_en | output | 1 | Twiddle read request |
| tw_addr | output | TWW | Twiddle address |
| tw_data | input | DW | Twiddle value, valid one cycle after the request |

## Verification
The bench builds two copies of the engine with N = 16 and DW = 32, one with EPOCH = 0 and one with EPOCH = 1, and gives each its own cache and a twiddle table built for its base. N = 16 makes the full four-stage run short enough to compare every output word with a direct O(N²) transform in every case. Within that size the bench covers both stage kinds and the exact done latency, using the small prime 7681 and the 32-bit prime 4293918721. The large prime drives the sum and difference paths to their carry and wrap limits.

// File: rtl/ntt_pkg.sv
package ntt_pkg;

    // Sequencer states of the packed NTT engine
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2
    } eng_state_t;

endpackage

// File: rtl/ntt_addr_gen.sv
module ntt_addr_gen #(
    parameter int N     = 256,
    parameter bit EPOCH = 1'b0,
    localparam int LOG_N = $clog2(N),
    localparam int AW    = LOG_N,
    localparam int SW    = $clog2(LOG_N),
    localparam int CW    = LOG_N - 1,
    localparam int TWW   = $clog2((N / 2) * (LOG_N + 1))
) (
    input  logic [SW-1:0]  stage,
    input  logic [CW-1:0]  cnt,
    output logic [AW-1:0]  rd_addr,
    output logic [AW-1:0]  wa_lo,
    output logic [AW-1:0]  wa_hi,
    output logic [TWW-1:0] tw_addr
);
    localparam int HALF    = N / 2;
    localparam int QTR     = N / 4;
    localparam int TW_BASE = EPOCH ? HALF : 0;

    logic [AW-1:0] r_ext;
    logic [AW-1:0] hmask;
    logic [AW-1:0] base;
    logic [AW-1:0] bit_s;

    always_comb begin
        // iteration index; two reads (A then B) per iteration
        r_ext = AW'(cnt >> 1);
        hmask = {AW{1'b1}} << stage;
        // A address: iteration index with a zero inserted at bit position 'stage'
        base  = (r_ext & ~hmask) | ((r_ext & hmask) << 1);
        bit_s = AW'(1) << stage;
        if (stage == SW'(LOG_N - 1)) begin
            // final stage: adjacent words, results land in the upper half
            rd_addr = AW'(cnt);
            wa_lo   = AW'(HALF) + r_ext;
            wa_hi   = AW'(HALF + QTR) + r_ext;
        end else begin
            rd_addr = cnt[0] ? (base | bit_s) : base;
            wa_lo   = base;
            wa_hi   = base | bit_s;
        end
        tw_addr = TWW'(TW_BASE) + TWW'(stage) * TWW'(HALF) + TWW'(cnt);
    end

endmodule

// File: rtl/ntt_bfly_pipe.sv
module ntt_bfly_pipe #(
    parameter int DW   = 32,
    parameter int TAGW = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_v,
    input  logic [TAGW-1:0] in_tag,
    input  logic [2*DW-1:0] word,
    input  logic [DW-1:0]   tw,
    input  logic [DW-1:0]   q,
    output logic            out_v,
    output logic [TAGW-1:0] out_tag,
    output logic [DW-1:0]   out_lo,
    output logic [DW-1:0]   out_hi,
    output logic            pipe_busy
);
    logic            v1, v2;
    logic [TAGW-1:0] tag1, tag2;
    logic [DW-1:0]   u1, u2, t2;
    logic [2*DW-1:0] prod1;
    logic [DW:0]     sum_w, sum_red, dif_w;

    always_comb begin
        sum_w   = {1'b0, u2} + {1'b0, t2};
        sum_red = (sum_w >= {1'b0, q}) ? (sum_w - {1'b0, q}) : sum_w;
        dif_w   = (u2 >= t2) ? ({1'b0, u2} - {1'b0, t2})
                             : ({1'b0, u2} + {1'b0, q} - {1'b0, t2});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0; out_v <= 1'b0;
            tag1 <= '0; tag2 <= '0; out_tag <= '0;
            u1 <= '0; u2 <= '0; t2 <= '0; prod1 <= '0;
            out_lo <= '0; out_hi <= '0;
        end else begin
            // stage 1: multiply the upper coefficient by the twiddle
            v1    <= in_v;
            tag1  <= in_tag;
            u1    <= word[DW-1:0];
            prod1 <= {{DW{1'b0}}, word[2*DW-1:DW]} * {{DW{1'b0}}, tw};
            // stage 2: reduce the product
            v2    <= v1;
            tag2  <= tag1;
            u2    <= u1;
            t2    <= DW'(prod1 % {{DW{1'b0}}, q});
            // stage 3: modular add and subtract
            out_v   <= v2;
            out_tag <= tag2;
            out_lo  <= sum_red[DW-1:0];
            out_hi  <= dif_w[DW-1:0];
        end
    end

    assign pipe_busy = v1 | v2 | out_v;

    // R6: butterfly results are fully reduced
    p_reduced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_v |-> ((out_lo < q) && (out_hi < q)));

endmodule

// File: rtl/ntt_pair_writer.sv
module ntt_pair_writer #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_v,
    input  logic            in_second,
    input  logic [AW-1:0]   in_wa_lo,
    input  logic [AW-1:0]   in_wa_hi,
    input  logic [DW-1:0]   in_lo,
    input  logic [DW-1:0]   in_hi,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [2*DW-1:0] wr_data,
    output logic            pend_v
);
    logic [DW-1:0]   held_lo, held_hi;
    logic [AW-1:0]   pend_addr;
    logic [2*DW-1:0] pend_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_lo   <= '0;
            held_hi   <= '0;
            pend_v    <= 1'b0;
            pend_addr <= '0;
            pend_data <= '0;
        end else begin
            if (in_v && !in_second) begin
                held_lo <= in_lo;
                held_hi <= in_hi;
            end
            pend_v <= in_v && in_second;
            if (in_v && in_second) begin
                pend_addr <= in_wa_hi;
                pend_data <= {in_hi, held_hi};
            end
        end
    end

    always_comb begin
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        if (in_v && in_second) begin
            wr_en   = 1'b1;
            wr_addr = in_wa_lo;
            wr_data = {in_lo, held_lo};
        end else if (pend_v) begin
            wr_en   = 1'b1;
            wr_addr = pend_addr;
            wr_data = pend_data;
        end
    end

    // R7: every second beat directly follows the first beat of its pair
    p_pair_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_v && in_second) |-> $past(in_v && !in_second));

endmodule

// File: rtl/ntt_packed_engine.sv
module ntt_packed_engine
    import ntt_pkg::*;
#(
    parameter int N     = 256,
    parameter int DW    = 32,
    parameter bit EPOCH = 1'b0,
    localparam int LOG_N = $clog2(N),
    localparam int AW    = LOG_N,
    localparam int TWW   = $clog2((N / 2) * (LOG_N + 1))
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [DW-1:0]   modulus,
    output logic            busy,
    output logic            done,
    output logic            cache_rd_en,
    output logic [AW-1:0]   cache_rd_addr,
    input  logic [2*DW-1:0] cache_rd_data,
    output logic            cache_wr_en,
    output logic [AW-1:0]   cache_wr_addr,
    output logic [2*DW-1:0] cache_wr_data,
    output logic            tw_rd_en,
    output logic [TWW-1:0]  tw_addr,
    input  logic [DW-1:0]   tw_data
);
    localparam int HALF = N / 2;
    localparam int SW   = $clog2(LOG_N);
    localparam int CW   = LOG_N - 1;
    localparam int TAGW = 1 + 2 * AW;

    eng_state_t    state, nxt;
    logic [SW-1:0] stage;
    logic [CW-1:0] cnt;
    logic          last_stage, issue_end, pipe_empty;

    logic [AW-1:0] ag_rd, ag_wlo, ag_whi;
    logic          s1_v;
    logic [TAGW-1:0] s1_tag;

    logic            bf_v, bf_busy, pend_v;
    logic [TAGW-1:0] bf_tag;
    logic [DW-1:0]   bf_lo, bf_hi;

    assign last_stage = (stage == SW'(LOG_N - 1));
    assign issue_end  = (cnt == CW'(HALF - 1));
    assign pipe_empty = !s1_v && !bf_busy && !pend_v;

    ntt_addr_gen #(.N(N), .EPOCH(EPOCH)) u_addr (
        .stage   (stage),
        .cnt     (cnt),
        .rd_addr (ag_rd),
        .wa_lo   (ag_wlo),
        .wa_hi   (ag_whi),
        .tw_addr (tw_addr)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start)      nxt = ST_ISSUE;
            ST_ISSUE: if (issue_end)  nxt = ST_DRAIN;
            ST_DRAIN: if (pipe_empty) nxt = last_stage ? ST_IDLE : ST_ISSUE;
            default:                  nxt = ST_IDLE;
        endcase
    end

    // state register and stage/iteration counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            stage <= '0;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE) begin
                stage <= '0;
                cnt   <= '0;
            end else if (state == ST_ISSUE) begin
                cnt <= cnt + 1'b1;
            end else if (state == ST_DRAIN && pipe_empty && !last_stage) begin
                stage <= stage + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy          = (state != ST_IDLE);
        cache_rd_en   = (state == ST_ISSUE);
        tw_rd_en      = (state == ST_ISSUE);
        cache_rd_addr = ag_rd;
        done          = (state == ST_DRAIN) && pipe_empty && last_stage;
    end

    // beat tag aligned with returning read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v   <= 1'b0;
            s1_tag <= '0;
        end else begin
            s1_v   <= cache_rd_en;
            s1_tag <= {cnt[0], ag_wlo, ag_whi};
        end
    end

    ntt_bfly_pipe #(.DW(DW), .TAGW(TAGW)) u_bfly (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_v      (s1_v),
        .in_tag    (s1_tag),
        .word      (cache_rd_data),
        .tw        (tw_data),
        .q         (modulus),
        .out_v     (bf_v),
        .out_tag   (bf_tag),
        .out_lo    (bf_lo),
        .out_hi    (bf_hi),
        .pipe_busy (bf_busy)
    );

    ntt_pair_writer #(.AW(AW), .DW(DW)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_v      (bf_v),
        .in_second (bf_tag[TAGW-1]),
        .in_wa_lo  (bf_tag[2*AW-1:AW]),
        .in_wa_hi  (bf_tag[AW-1:0]),
        .in_lo     (bf_lo),
        .in_hi     (bf_hi),
        .wr_en     (cache_wr_en),
        .wr_addr   (cache_wr_addr),
        .wr_data   (cache_wr_data),
        .pend_v    (pend_v)
    );

    // R1: no cache traffic while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cache_rd_en && !cache_wr_en));

    // R2: done is a single-cycle pulse
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: done follows the last committed write
    p_done_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cache_wr_en));

    // R3: once launched, busy holds until done regardless of start
    p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R7: reads stay in the lower half of the cache
    p_rd_lower_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cache_rd_en |-> (cache_rd_addr < AW'(HALF)));

endmodule

// File: tb/ntt_packed_engine_test.sv
module ntt_packed_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 16;
    localparam int DW    = 32;
    localparam int L     = 4;
    localparam int HALF  = N / 2;
    localparam int AW    = L;
    localparam int TWW   = $clog2(HALF * (L + 1));
    localparam int TWD   = HALF * (L + 1);
    localparam int LAT   = L * (HALF + 6);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [DW-1:0] modulus = 32'd7681;

    int nchk = 0;
    int nerr = 0;

    // instance with EPOCH 0
    logic            busy0, done0, rd0_en, wr0_en, tw0_en;
    logic [AW-1:0]   rd0_addr, wr0_addr;
    logic [2*DW-1:0] rd0_data, wr0_data;
    logic [TWW-1:0]  tw0_addr;
    logic [DW-1:0]   tw0_data;
    // instance with EPOCH 1
    logic            busy1, done1, rd1_en, wr1_en, tw1_en;
    logic [AW-1:0]   rd1_addr, wr1_addr;
    logic [2*DW-1:0] rd1_data, wr1_data;
    logic [TWW-1:0]  tw1_addr;
    logic [DW-1:0]   tw1_data;

    logic [2*DW-1:0] mem0 [0:N-1];
    logic [2*DW-1:0] mem1 [0:N-1];
    logic [DW-1:0]   twt0 [0:TWD-1];
    logic [DW-1:0]   twt1 [0:TWD-1];

    logic [DW-1:0] a_in  [0:N-1];
    logic [DW-1:0] x_ref [0:N-1];
    logic [DW-1:0] wp    [0:N-1];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ntt_packed_engine #(.N(N), .DW(DW), .EPOCH(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .modulus(modulus),
        .busy(busy0), .done(done0),
        .cache_rd_en(rd0_en), .cache_rd_addr(rd0_addr), .cache_rd_data(rd0_data),
        .cache_wr_en(wr0_en), .cache_wr_addr(wr0_addr), .cache_wr_data(wr0_data),
        .tw_rd_en(tw0_en), .tw_addr(tw0_addr), .tw_data(tw0_data)
    );

    ntt_packed_engine #(.N(N), .DW(DW), .EPOCH(1'b1)) uut_ep1 (
        .clk(clk), .rst_n(rst_n), .start(start), .modulus(modulus),
        .busy(busy1), .done(done1),
        .cache_rd_en(rd1_en), .cache_rd_addr(rd1_addr), .cache_rd_data(rd1_data),
        .cache_wr_en(wr1_en), .cache_wr_addr(wr1_addr), .cache_wr_data(wr1_data),
        .tw_rd_en(tw1_en), .tw_addr(tw1_addr), .tw_data(tw1_data)
    );

    // cache and twiddle store models, one-cycle read latency
    always @(posedge clk) begin
        if (wr0_en) mem0[wr0_addr] <= wr0_data;
        if (rd0_en) rd0_data <= mem0[rd0_addr];
        if (tw0_en) tw0_data <= twt0[tw0_addr];
        if (wr1_en) mem1[wr1_addr] <= wr1_data;
        if (rd1_en) rd1_data <= mem1[rd1_addr];
        if (tw1_en) tw1_data <= twt1[tw1_addr];
    end

    function automatic logic [DW-1:0] mulmod(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                             input logic [DW-1:0] q);
        longint unsigned p;
        p = longint'(a) * longint'(b);
        return DW'(p % longint'(q));
    endfunction

    function automatic logic [DW-1:0] powmod(input logic [DW-1:0] b, input longint unsigned e,
                                             input logic [DW-1:0] q);
        logic [DW-1:0] r, x;
        longint unsigned k;
        r = DW'(1); x = b; k = e;
        while (k != 0) begin
            if (k[0]) r = mulmod(r, x, q);
            x = mulmod(x, x, q);
            k = k >> 1;
        end
        return r;
    endfunction

    function automatic int bitrev(input int e);
        int r;
        r = 0;
        for (int i = 0; i < L; i++) if (e[i]) r = r | (1 << (L - 1 - i));
        return r;
    endfunction

    function automatic int tw_exp(input int s, input int c);
        if (s == L - 1) return c;
        return ((c >> 1) & ((1 << s) - 1)) * (N >> (s + 1));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // root of unity search and twiddle tables (R8, R9)
    task automatic build_tables(input logic [DW-1:0] q);
        logic [DW-1:0] w;
        int x;
        x = 2;
        w = powmod(DW'(x), longint'((q - 1) / N), q);
        while (powmod(w, HALF, q) != q - 1 && x < 1000) begin
            x++;
            w = powmod(DW'(x), longint'((q - 1) / N), q);
        end
        for (int k = 0; k < N; k++) wp[k] = powmod(w, k, q);
        for (int k = 0; k < TWD; k++) begin
            twt0[k] = '0;
            twt1[k] = '0;
        end
        for (int k = 0; k < HALF * L; k++) begin
            twt0[k]        = wp[tw_exp(k / HALF, k % HALF)];
            twt1[k + HALF] = wp[tw_exp(k / HALF, k % HALF)];
        end
    endtask

    task automatic run_case(input string name, input logic [DW-1:0] q, input int extra_at);
        int done_at0, done_at1, dcnt0, dcnt1, rds, wrs, bad_rd;
        logic [TWW-1:0] first_tw0, first_tw1;
        logic [DW-1:0] acc;
        modulus = q;
        build_tables(q);
        for (int k = 0; k < N; k++) begin
            acc = '0;
            for (int j = 0; j < N; j++)
                acc = DW'((longint'(acc) + longint'(mulmod(a_in[j], wp[(j * k) % N], q))) % longint'(q));
            x_ref[k] = acc;
        end
        // R4: packed bit-reversed input in the lower half
        for (int p = 0; p < HALF; p++) begin
            mem0[p] <= {a_in[bitrev(2 * p + 1)], a_in[bitrev(2 * p)]};
            mem1[p] <= {a_in[bitrev(2 * p + 1)], a_in[bitrev(2 * p)]};
            mem0[p + HALF] <= 64'hFFFF_FFFF_FFFF_FFFF;
            mem1[p + HALF] <= 64'hFFFF_FFFF_FFFF_FFFF;
        end
        done_at0 = -1; done_at1 = -1; dcnt0 = 0; dcnt1 = 0;
        rds = 0; wrs = 0; bad_rd = 0; first_tw0 = '0; first_tw1 = '0;
        @(negedge clk);
        start = 1'b1;
        for (int k = 1; k <= LAT + 12; k++) begin
            @(negedge clk);
            if (k == 1) begin
                check(busy0 && busy1, "R2", {name, " busy after start"}, 64'(busy0), 64'd1);
                first_tw0 = tw0_addr;
                first_tw1 = tw1_addr;
            end
            if (done0) begin dcnt0++; if (done_at0 < 0) done_at0 = k; end
            if (done1) begin dcnt1++; if (done_at1 < 0) done_at1 = k; end
            if (rd0_en) begin rds++; if (rd0_addr >= AW'(HALF)) bad_rd++; end
            if (wr0_en) wrs++;
            start = (k + 1 == extra_at);
        end
        start = 1'b0;
        check(done_at0 == LAT, "R2", {name, " done cycle"}, 64'(done_at0), 64'(LAT));
        check(done_at1 == LAT, "R2", {name, " done cycle epoch1"}, 64'(done_at1), 64'(LAT));
        check(dcnt0 == 1 && dcnt1 == 1, "R3", {name, " done pulses"}, 64'(dcnt0), 64'd1);
        check(!busy0 && !busy1, "R2", {name, " idle after done"}, 64'(busy0), 64'd0);
        check(rds == L * HALF, "R7", {name, " read count"}, 64'(rds), 64'(L * HALF));
        check(wrs == L * HALF, "R7", {name, " write count"}, 64'(wrs), 64'(L * HALF));
        check(bad_rd == 0, "R7", {name, " upper-half reads"}, 64'(bad_rd), 64'd0);
        check(first_tw0 == '0, "R9", {name, " epoch0 twiddle base"}, 64'(first_tw0), 64'd0);
        check(first_tw1 == TWW'(HALF), "R9", {name, " epoch1 twiddle base"}, 64'(first_tw1), 64'(HALF));
        // R5, R6, R8, R10: natural-order packed output in the upper half
        for (int p = 0; p < HALF; p++) begin
            check(mem0[HALF + p] == {x_ref[2 * p + 1], x_ref[2 * p]}, "R5",
                  {name, " output word"}, mem0[HALF + p], {x_ref[2 * p + 1], x_ref[2 * p]});
            check(mem1[HALF + p] == {x_ref[2 * p + 1], x_ref[2 * p]}, "R8",
                  {name, " epoch1 output word"}, mem1[HALF + p], {x_ref[2 * p + 1], x_ref[2 * p]});
            check(mem0[HALF + p][31:0] < q && mem0[HALF + p][63:32] < q, "R6",
                  {name, " reduced"}, mem0[HALF + p], 64'(q));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nerr++;
        $display("FAIL watchdog: run did not complete, actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd4711);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy0 && !done0, "R1", "idle after reset", 64'({busy0, done0}), 64'd0);
        check(!rd0_en && !wr0_en && !tw0_en, "R1", "no traffic after reset",
              64'({rd0_en, wr0_en, tw0_en}), 64'd0);

        // R10 impulse: every X equals 1
        for (int j = 0; j < N; j++) a_in[j] = '0;
        a_in[0] = 32'd1;
        run_case("impulse", 32'd7681, -1);

        // R10 shifted impulse exercises every twiddle power
        for (int j = 0; j < N; j++) a_in[j] = '0;
        a_in[1] = 32'd1;
        run_case("shifted impulse", 32'd7681, -1);

        for (int j = 0; j < N; j++) a_in[j] = 32'd7680;
        run_case("all q-1 small", 32'd7681, -1);

        for (int j = 0; j < N; j++) a_in[j] = '0;
        run_case("zeros", 32'd7681, -1);

        for (int r = 0; r < 3; r++) begin
            for (int j = 0; j < N; j++) a_in[j] = $urandom % 32'd7681;
            run_case("random small", 32'd7681, -1);
        end

        // R3: start pulsed mid-run is ignored
        for (int j = 0; j < N; j++) a_in[j] = $urandom % 32'd7681;
        run_case("start while busy", 32'd7681, 10);

        for (int r = 0; r < 2; r++) begin
            for (int j = 0; j < N; j++) a_in[j] = $urandom % 32'd4293918721;
            run_case("random large", 32'd4293918721, -1);
        end
        for (int j = 0; j < N; j++) a_in[j] = 32'd4293918720;
        run_case("all q-1 large", 32'd4293918721, -1);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule